// File: doc/BRIEF.md
# Shadowed PWM Channel with Boundary-Aligned Update

A single pulse-width output whose settings (clock divider, period, duty count and output inversion) are written into staging registers through a plain address/data write port. Staged values do nothing until software raises the channel enable bit and keeps it raised for a minimum hold window. Only then is the staged set copied into the working registers that drive the waveform counter. Raising the enable bit and dropping it again before the window ends leaves the running waveform untouched.

A smooth bit in the control word picks how a committed set takes over. With the bit clear, the copy lands at once and the counter restarts. With the bit set, the copy waits for the end of the current period, so no period is ever cut short. The smooth bit also decides what a low enable bit means. With smooth clear, a low enable bit holds the channel logic in reset and drives the output high. With smooth set, the old waveform keeps running untouched.

The hold window and the minimum low time between two enables are both derived from the clock frequency and a time figure in nanoseconds. The default is 400 ns at 200 MHz, which gives 80 cycles.

Top module: `pwm_shadow_chan`

## Requirements
- R1: After reset, and on every cycle where enable is 0 and smooth is 0, `pwm_o` is 1 and the counter is held at its start. When enable rises, the counter runs from count 0 using the working settings.
- R2: Write address 0 sets the staged divider from data bits [7:0]. Address 1 sets the staged period from bits [23:0]. Address 2 sets the staged duty count from bits [23:0]. Address 3 is the control word: bit 0 is enable, bit 1 is smooth, and bit 2 is the staged polarity.
- R3: The count advances once every divider+1 clock cycles and wraps to 0 after reaching period-1. The output is active while count < duty. `pwm_o` equals the active level XOR the polarity bit.
- R4: A duty greater than or equal to the period gives a constant active level, including the full-scale duty 0xFFFFFF. A duty of 0 gives a constant inactive level. This includes the off set of divider 0, period 0 and duty 0.
- R5: A commit happens at the clock edge where enable has been 1 for HOLD_CYC consecutive cycles. HOLD_CYC is 80 at the defaults. With smooth clear, the new set drives the output from that edge, starting at count 0. There is at most one commit per high phase of enable.
- R6: If enable is 1 for fewer than HOLD_CYC cycles, the staged values are discarded and the working settings stay as they were.
- R7: If enable rises after being 0 for fewer than HOLD_CYC cycles, no commit is made during that high phase.
- R8: With smooth set at commit time, the new set takes over only at the next period wrap, and the count restarts from 0 there.
- R9: With smooth set, a 0 on enable does not stop or restart the waveform. It keeps running from the working settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 24 | Register write data |
| pwm_o | output | 1 | PWM output |

## Verification
The bench checks the one-cycle edges of the hold window. A design that commits a cycle early shows the new waveform at the last hold cycle. A design that accepts a short pulse or a short gap corrupts the running waveform; in the short-gap case the inverted staged polarity would show on the output. For smooth mode, the commit is placed mid-period and the old period must finish, so a design that loads at once breaks the phase. The low-enable cases are also checked: with smooth set, a design that restarts or stops the counter loses the phase, and with smooth clear, a design that keeps running fails to hold the output high. The constant-level cases use a full-scale 24-bit duty and the all-zero off set, so both duty comparisons and the period-0 wrap are exercised.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int PS_W   = 8;
  localparam int CNT_W  = 24;
  localparam int ADDR_W = 2;
  localparam int DATA_W = CNT_W;

  localparam int CTRL_EN_BIT     = 0;
  localparam int CTRL_SMOOTH_BIT = 1;
  localparam int CTRL_POL_BIT    = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIV    = 2'd0,
    REG_PERIOD = 2'd1,
    REG_DUTY   = 2'd2,
    REG_CTRL   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [PS_W-1:0]  div;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] duty;
    logic             pol;
  } wave_cfg_t;
endpackage

// File: rtl/pwm_stage_regs.sv
module pwm_stage_regs
  import pwm_shadow_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output wave_cfg_t         staged_o,
  output logic              en_o,
  output logic              smooth_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      staged_o <= '0;
      en_o     <= 1'b0;
      smooth_o <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        REG_DIV:    staged_o.div    <= wr_data_i[PS_W-1:0];
        REG_PERIOD: staged_o.period <= wr_data_i[CNT_W-1:0];
        REG_DUTY:   staged_o.duty   <= wr_data_i[CNT_W-1:0];
        REG_CTRL: begin
          en_o         <= wr_data_i[CTRL_EN_BIT];
          smooth_o     <= wr_data_i[CTRL_SMOOTH_BIT];
          staged_o.pol <= wr_data_i[CTRL_POL_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pwm_commit_ctrl.sv
module pwm_commit_ctrl #(
  parameter int HOLD_CYC = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic commit_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HOLD_L  = HW'(HOLD_CYC);
  localparam logic [HW-1:0] HOLD_M1 = HW'(HOLD_CYC - 1);

  logic [HW-1:0] hcnt_q, gcnt_q;
  logic          en_prev_q, armed_q, done_q;

  assign commit_o = en_i && armed_q && !done_q && (hcnt_q == HOLD_M1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q    <= '0;
      gcnt_q    <= HOLD_L;  // first enable after reset is accepted
      en_prev_q <= 1'b0;
      armed_q   <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      en_prev_q <= en_i;
      if (!en_i) begin
        hcnt_q  <= '0;
        done_q  <= 1'b0;
        armed_q <= 1'b0;
        if (gcnt_q != HOLD_L) gcnt_q <= gcnt_q + 1'b1;
      end else begin
        gcnt_q <= '0;
        if (!en_prev_q) armed_q <= (gcnt_q == HOLD_L);
        if (!done_q && hcnt_q != HOLD_M1) hcnt_q <= hcnt_q + 1'b1;
        if (commit_o) done_q <= 1'b1;
      end
    end
  end

  // R6: a commit only ever comes out of a continuing high phase
  a_r6_commit_in_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (en_i && $past(en_i)));
  // R5: one commit per high phase
  a_r5_single_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);
  // R7: a rise after a short gap never arms
  a_r7_short_gap_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !en_prev_q && gcnt_q != HOLD_L) |=> !armed_q);
endmodule

// File: rtl/pwm_wave_core.sv
module pwm_wave_core
  import pwm_shadow_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  wave_cfg_t cfg_i,
  input  logic      commit_i,
  input  logic      smooth_i,
  input  logic      en_i,
  output logic      pwm_o
);
  wave_cfg_t        work_q, pend_q;
  logic             pend_v_q;
  logic [PS_W-1:0]  pc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hold_rst, tick, wrap, load_now, load_bnd;

  assign hold_rst = !en_i && !smooth_i;
  assign tick     = (pc_q == work_q.div);
  assign wrap     = tick && ((work_q.period == '0) || (cnt_q >= work_q.period - 1'b1));
  assign load_now = commit_i && !smooth_i;
  assign load_bnd = wrap && pend_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_q   <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      pc_q     <= '0;
      cnt_q    <= '0;
    end else if (hold_rst) begin
      pc_q     <= '0;
      cnt_q    <= '0;
      pend_v_q <= 1'b0;
    end else if (load_now) begin
      work_q   <= cfg_i;
      pc_q     <= '0;
      cnt_q    <= '0;
      pend_v_q <= 1'b0;
    end else begin
      pc_q <= tick ? '0 : pc_q + 1'b1;
      if (wrap)      cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
      if (load_bnd) begin
        work_q   <= pend_q;
        pend_v_q <= 1'b0;
      end
      if (commit_i) begin  // smooth: park until period wrap
        pend_q   <= cfg_i;
        pend_v_q <= 1'b1;
      end
    end
  end

  assign pwm_o = hold_rst ? 1'b1 : ((cnt_q < work_q.duty) ^ work_q.pol);

  // R8: working set changes only on an immediate load or a period wrap
  a_r8_work_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_now || load_bnd) |=> $stable(work_q));
  // R3: count stays inside the period
  a_r3_cnt_in_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (work_q.period != '0) |-> (cnt_q < work_q.period));
  // R1: idle without smooth holds the counter at its start
  a_r1_idle_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_rst |=> (cnt_q == '0 && pc_q == '0));
endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan
  import pwm_shadow_pkg::*;
#(
  parameter int CLK_MHZ = 200,
  parameter int HOLD_NS = 400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              pwm_o
);
  localparam int HOLD_CYC = (CLK_MHZ * HOLD_NS + 999) / 1000;

  wave_cfg_t staged;
  logic      en, smooth, commit;

  pwm_stage_regs u_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .staged_o (staged),
    .en_o     (en),
    .smooth_o (smooth)
  );

  pwm_commit_ctrl #(.HOLD_CYC(HOLD_CYC)) u_commit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .commit_o(commit)
  );

  pwm_wave_core u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_i   (staged),
    .commit_i(commit),
    .smooth_i(smooth),
    .en_i    (en),
    .pwm_o   (pwm_o)
  );
endmodule

// File: tb/sim_pwm_shadow_chan.sv
`timescale 1ns/1ps
module sim_pwm_shadow_chan;
  localparam int HOLD = 80;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [23:0] wr_data = '0;
  logic        pwm;

  pwm_shadow_chan u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .pwm_o(pwm)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int at; logic val; string req; } exp_t;
  exp_t q[$];
  exp_t e;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // monitor: pops expectations due this cycle
  initial forever begin
    @(negedge clk);
    while (q.size() > 0 && q[0].at <= cyc) begin
      e = q.pop_front();
      checks++;
      if (e.at != cyc || pwm !== e.val) begin
        errors++;
        $display("FAIL %s cycle %0d: pwm_o=%b expected %b", e.req, e.at, pwm, e.val);
      end
    end
  end

  task automatic push(input int at, input logic v, input string r);
    exp_t x;
    x.at = at; x.val = v; x.req = r;
    q.push_back(x);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [23:0] d, output int at);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    at = cyc;
  endtask

  task automatic ctl(input logic en, input logic sm, input logic pol, output int at);
    wr(2'd3, {21'd0, pol, sm, en}, at);
  endtask

  task automatic stage(input int dv, input int per, input int dut);
    int t;
    wr(2'd0, 24'(dv), t);
    wr(2'd1, 24'(per), t);
    wr(2'd2, 24'(dut), t);
  endtask

  int cb;  // edge where the first waveform restarted at count 0
  function automatic logic wave_b(input int t);
    return ((t - cb) % 8) < 4;
  endfunction

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    int c, cf, cr, tb0;
    idle(3);
    rst_ni = 1'b1;
    // R1: reset level
    for (int j = 1; j <= 3; j++) push(cyc + j, 1'b1, "R1");
    drain();

    // R2 R3 R5: immediate commit, divider 1, period 4, duty 2
    stage(1, 4, 2);
    ctl(1'b1, 1'b0, 1'b0, c);
    cb = c + HOLD;
    push(c + 1, 1'b0, "R1");
    push(c + HOLD - 1, 1'b0, "R5");
    for (int j = 0; j < 16; j++) push(cb + j, wave_b(cb + j), "R2 R3");
    drain();

    // R9: smooth set, enable low keeps the waveform running
    ctl(1'b1, 1'b1, 1'b0, c);
    stage(0, 6, 3);
    ctl(1'b0, 1'b1, 1'b0, cf);
    for (int t = cf + 1; t <= cf + HOLD + 5; t++) push(t, wave_b(t), "R9");
    drain();
    idle(HOLD + 5);

    // R6: short high pulse is discarded
    ctl(1'b1, 1'b1, 1'b0, cr);
    for (int t = cr + 1; t <= cr + HOLD + 40; t++) push(t, wave_b(t), "R6");
    idle(HOLD - 20);
    ctl(1'b0, 1'b1, 1'b0, cf);
    drain();
    idle(HOLD + 5);

    // R8: smooth commit waits for the period wrap
    ctl(1'b1, 1'b1, 1'b0, cr);
    tb0 = cr + HOLD + 1;
    tb0 = tb0 + ((8 - ((tb0 - cb) % 8)) % 8);
    for (int t = cr + 1; t <= tb0 + 20; t++)
      push(t, (t < tb0) ? wave_b(t) : (((t - tb0) % 6) < 3), "R8");
    drain();

    // R1: smooth clear, enable low forces output high
    ctl(1'b0, 1'b0, 1'b0, cf);
    for (int j = 1; j <= 10; j++) push(cf + j, 1'b1, "R1");
    drain();
    idle(5);

    // R7: short gap, no commit (staged polarity 1 must not appear)
    ctl(1'b1, 1'b0, 1'b1, cr);
    for (int t = cr + 1; t <= cr + HOLD + 30; t++) push(t, ((t - cr) % 6) < 3, "R7");
    drain();

    // R4: full-scale duty above period, inverted -> constant 0
    ctl(1'b0, 1'b0, 1'b1, cf);
    idle(HOLD + 5);
    stage(2, 3, 24'hFFFFFF);
    ctl(1'b1, 1'b0, 1'b1, c);
    push(c + HOLD - 1, ((HOLD - 1) % 6) < 3, "R5");
    for (int j = 0; j < 13; j++) push(c + HOLD + j, 1'b0, "R4");
    drain();

    // R4: off set (all zero), inverted -> constant 1
    ctl(1'b0, 1'b0, 1'b1, cf);
    idle(HOLD + 5);
    stage(0, 0, 0);
    ctl(1'b1, 1'b0, 1'b1, c);
    push(c + HOLD - 1, 1'b0, "R5");
    for (int j = 0; j < 13; j++) push(c + HOLD + j, 1'b1, "R4");
    drain();

    idle(2);
    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      report();
      $finish;
    end
  end
endmodule